// File: doc/BRIEF.md
# Key-Protected Clock Peripheral Register File

This block holds the software-visible configuration state of a clock peripheral: a control byte, a status byte with sticky event flags, an interrupt enable word, an oscillator control byte, and three general 32-bit scratch words. It connects to a simple synchronous bus. Each access is one cycle long and carries an address, a write flag, write data and a width flag that selects a full word or only the low byte.

Every register that holds state is guarded by a pair of 32-bit key registers. A write to a guarded register takes effect only while both keys hold their magic values. Otherwise the write is dropped without any response. Reads are never blocked. Software unlocks the block by writing both keys and locks it again by writing zeros to them. Two event inputs from the time-keeping logic set the sticky status flags, and software clears them by writing ones. The stored configuration is driven out on ports to the rest of the peripheral.

Top module: `kreg_file`

## Requirements
- R1: The block is unlocked only while the key register at 0x6C holds 0x83E70B13 and the key register at 0x70 holds 0x95A4F1E0, both at once. A write to the control, status, interrupt enable, oscillator or scratch registers takes effect only while the block is unlocked.
- R2: Writing any value other than its magic value to either key register locks the block, and writing zero to both keys locks it. Key registers always accept writes and read back as 0.
- R3: While the block is locked, writes to guarded registers are dropped and leave both the stored value and the output ports unchanged. Reads return the stored values whether the block is locked or not.
- R4: The control register is at 0x40 and is 8 bits wide. Bit 0 is the run bit and bit 7 is the split-power bit. `ctrl_o` shows all 8 stored bits, but bit 7 always reads back as 0 on the bus. Status bit 1 reads as the control run bit.
- R5: The status register is at 0x44. Bit 7 (power-up) is set by reset, and bit 6 (alarm) is set by a pulse on `alarm_hit`. Writing 1 to bit 6 or bit 7 clears that bit, and writing 0 leaves it unchanged. If an event and a clearing write land in the same cycle, the event wins. All other status bits except bit 1 read as 0.
- R6: A pulse on `alarm2_hit` sets status bit 7. The bit is then cleared the same way as the power-up flag.
- R7: The interrupt enable register is at 0x48. Its implemented bits are bits 4:0 and bit 8 (the second-alarm enable), and all other bits read 0. A byte write changes only bits 7:0, so it cannot change bit 8. A word write of zero clears every enable bit.
- R8: The oscillator control register is at 0x54. Only bits 6 (32 kHz clock enable), 4 (oscillator disable) and 3 (external source select) are stored, and all other bits read 0.
- R9: The three 32-bit scratch words are at 0x60, 0x64 and 0x68. Address 0x6C is a key register, not scratch space.
- R10: A byte access (`bus_word`=0) writes only bits 7:0 of the target and keeps its upper bits. A byte read returns bits 7:0 with the upper bits set to 0.
- R11: Read data appears on `bus_rdata` on the clock edge that samples the read, and holds until the next read. Unmapped addresses read 0, and writes to them have no effect.
- R12: After reset the block is locked, and every register is 0 except status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access, 0 = low byte only |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| alarm_hit | input | 1 | Event pulse that sets the alarm flag |
| alarm2_hit | input | 1 | Event pulse that sets the second-alarm / power-up flag |
| ctrl_o | output | 8 | Stored control byte |
| irq_en_o | output | 9 | Stored interrupt enables (bit 8 = second alarm) |
| osc_o | output | 8 | Stored oscillator control byte |

## Verification
A write updates its register, and the output port that shows it, at the clock edge that samples the access. A read issued in the following cycle returns the new value at the edge after that. The bench therefore drives every access at a falling edge and samples `bus_rdata` or the output ports at the next falling edge. Event pulses reach the status flags at the edge where they are sampled. The set-versus-clear case drives the pulse and the clearing write in the same cycle and reads the flag one access later.

// File: rtl/kreg_pkg.sv
package kreg_pkg;

    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int N_SCR = 3;
    localparam int IRQ_W = 9;

    localparam logic [AW-1:0] A_CTRL = 8'h40;
    localparam logic [AW-1:0] A_STAT = 8'h44;
    localparam logic [AW-1:0] A_IRQ  = 8'h48;
    localparam logic [AW-1:0] A_OSC  = 8'h54;
    localparam logic [AW-1:0] A_SCR0 = 8'h60;
    localparam logic [AW-1:0] A_KEY0 = 8'h6C;
    localparam logic [AW-1:0] A_KEY1 = 8'h70;

    localparam logic [DW-1:0] KEY0_VAL = 32'h83E7_0B13;
    localparam logic [DW-1:0] KEY1_VAL = 32'h95A4_F1E0;

    localparam logic [7:0]       OSC_MASK = 8'h58;
    localparam logic [IRQ_W-1:0] IRQ_MASK = 9'h11F;

    typedef struct packed {
        logic          sel;
        logic          we;
        logic          word;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    // Byte accesses replace only the low byte of the old value
    function automatic logic [DW-1:0] merge_w(input logic [DW-1:0] old_v,
                                              input logic [DW-1:0] new_v,
                                              input logic          word);
        return word ? new_v : {old_v[DW-1:8], new_v[7:0]};
    endfunction

endpackage

// File: rtl/kreg_keys.sv
module kreg_keys
    import kreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     unlocked
);
    logic [DW-1:0] key0_q, key1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key0_q <= '0;
            key1_q <= '0;
        end else if (req.sel && req.we) begin
            if (req.addr == A_KEY0) key0_q <= merge_w(key0_q, req.wdata, req.word);
            if (req.addr == A_KEY1) key1_q <= merge_w(key1_q, req.wdata, req.word);
        end
    end

    assign unlocked = (key0_q == KEY0_VAL) && (key1_q == KEY1_VAL);

    // R2
    key_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (req.sel && req.we && req.word && req.addr == A_KEY1 && req.wdata != KEY1_VAL)
        |=> !unlocked);

    // R12
    lock_after_reset_chk: assert property (@(posedge clk) rst |=> !unlocked);

endmodule

// File: rtl/kreg_status.sv
module kreg_status
    import kreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       alarm_hit,
    input  logic       alarm2_hit,
    input  logic       run_bit,
    output logic [7:0] stat
);
    logic pwr_q, alm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= 1'b1;
            alm_q <= 1'b0;
        end else begin
            if (alarm2_hit)                pwr_q <= 1'b1;
            else if (wr_en && wbyte[7])    pwr_q <= 1'b0;
            if (alarm_hit)                 alm_q <= 1'b1;
            else if (wr_en && wbyte[6])    alm_q <= 1'b0;
        end
    end

    assign stat = {pwr_q, alm_q, 4'b0000, run_bit, 1'b0};

    // R5
    pwr_on_reset_chk: assert property (@(posedge clk) rst |=> pwr_q);

    // R5
    alarm_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> alm_q);

    // R6
    alarm2_set_chk: assert property (@(posedge clk) disable iff (rst)
        alarm2_hit |=> pwr_q);

endmodule

// File: rtl/kreg_store.sv
module kreg_store
    import kreg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_ctrl,
    input  logic                       wr_irq,
    input  logic                       wr_osc,
    input  logic [N_SCR-1:0]           wr_scr,
    input  logic                       word,
    input  logic [DW-1:0]              wdata,
    output logic [7:0]                 ctrl_q,
    output logic [IRQ_W-1:0]           irq_q,
    output logic [7:0]                 osc_q,
    output logic [N_SCR-1:0][DW-1:0]   scr_q
);
    logic [DW-1:0] irq_next;

    assign irq_next = merge_w({{(DW-IRQ_W){1'b0}}, irq_q}, wdata, word);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            osc_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[7:0];
            if (wr_irq)  irq_q  <= irq_next[IRQ_W-1:0] & IRQ_MASK;
            if (wr_osc)  osc_q  <= wdata[7:0] & OSC_MASK;
        end
    end

    for (genvar i = 0; i < N_SCR; i++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)            scr_q[i] <= '0;
            else if (wr_scr[i]) scr_q[i] <= merge_w(scr_q[i], wdata, word);
        end
    end

    // R7
    irq_byte_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_irq && !word) |=> $stable(irq_q[8]));

endmodule

// File: rtl/kreg_file.sv
module kreg_file
    import kreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic                bus_word,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                alarm_hit,
    input  logic                alarm2_hit,
    output logic [7:0]          ctrl_o,
    output logic [IRQ_W-1:0]    irq_en_o,
    output logic [7:0]          osc_o
);
    bus_req_t                   req;
    logic                       unlocked, prot_wr;
    logic [7:0]                 stat;
    logic [N_SCR-1:0]           wr_scr;
    logic [N_SCR-1:0][DW-1:0]   scr_q;
    logic [DW-1:0]              rd_val;

    assign req     = '{sel: bus_sel, we: bus_we, word: bus_word,
                       addr: bus_addr, wdata: bus_wdata};
    assign prot_wr = bus_sel && bus_we && unlocked;

    kreg_keys u_keys (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .unlocked (unlocked)
    );

    kreg_status u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (prot_wr && bus_addr == A_STAT),
        .wbyte      (bus_wdata[7:0]),
        .alarm_hit  (alarm_hit),
        .alarm2_hit (alarm2_hit),
        .run_bit    (ctrl_o[0]),
        .stat       (stat)
    );

    for (genvar i = 0; i < N_SCR; i++) begin : g_dec
        assign wr_scr[i] = prot_wr && (bus_addr == A_SCR0 + AW'(4 * i));
    end

    kreg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (prot_wr && bus_addr == A_CTRL),
        .wr_irq  (prot_wr && bus_addr == A_IRQ),
        .wr_osc  (prot_wr && bus_addr == A_OSC),
        .wr_scr  (wr_scr),
        .word    (bus_word),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_o),
        .irq_q   (irq_en_o),
        .osc_q   (osc_o),
        .scr_q   (scr_q)
    );

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            A_CTRL: rd_val = {24'b0, 1'b0, ctrl_o[6:0]};
            A_STAT: rd_val = {24'b0, stat};
            A_IRQ:  rd_val = {{(DW-IRQ_W){1'b0}}, irq_en_o};
            A_OSC:  rd_val = {24'b0, osc_o};
            default: begin
                for (int i = 0; i < N_SCR; i++)
                    if (bus_addr == A_SCR0 + AW'(4 * i)) rd_val = scr_q[i];
            end
        endcase
        if (!bus_word) rd_val = {24'b0, rd_val[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst)                   bus_rdata <= '0;
        else if (bus_sel && !bus_we) bus_rdata <= rd_val;
    end

    // R3
    locked_ctrl_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !unlocked && bus_addr == A_CTRL) |=> $stable(ctrl_o));

    // R4
    ctrl_split_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == A_CTRL) |=> !bus_rdata[7]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

// File: tb/test_kreg_file.sv
module test_kreg_file;
    import kreg_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b1;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            alarm_hit = 1'b0, alarm2_hit = 1'b0;
    logic [7:0]      ctrl_o, osc_o;
    logic [8:0]      irq_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    kreg_file i_kreg_file (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_hit(alarm_hit), .alarm2_hit(alarm2_hit),
        .ctrl_o(ctrl_o), .irq_en_o(irq_en_o), .osc_o(osc_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w = 1'b1);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_word = 1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic w = 1'b1);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_word = w; bus_addr = a;
        @(negedge clk);
        bus_sel = 0; bus_word = 1;
        d = bus_rdata;
    endtask

    task automatic unlock();
        wr(A_KEY0, KEY0_VAL);
        wr(A_KEY1, KEY1_VAL);
    endtask

    task automatic lock();
        wr(A_KEY0, 32'h0);
        wr(A_KEY1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R12 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R12/R5 status power-up", v, 32'h80);
        rd(A_IRQ, v);  chk("R12 irq", v, 32'h0);
        rd(A_OSC, v);  chk("R12 osc", v, 32'h0);
        rd(A_SCR0, v); chk("R12 scratch0", v, 32'h0);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        wr(A_CTRL, 32'h01);
        chk("R3 ctrl_o locked", {24'b0, ctrl_o}, 32'h0);
        rd(A_CTRL, v); chk("R3 ctrl read locked", v, 32'h0);
        wr(A_SCR0 + 8'h4, 32'hDEAD_BEEF);
        rd(A_SCR0 + 8'h4, v); chk("R3 scratch locked", v, 32'h0);
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); chk("R3 status w1c locked", v, 32'h80);
    endtask

    task automatic t_unlock_ctrl();
        logic [31:0] v;
        unlock();
        wr(A_CTRL, 32'hFF);
        chk("R1 R4 ctrl_o full", {24'b0, ctrl_o}, 32'hFF);
        rd(A_CTRL, v); chk("R4 split bit hidden", v, 32'h7F);
        rd(A_STAT, v); chk("R4 run mirrored", v, 32'h82);
        rd(A_KEY0, v); chk("R2 key reads zero", v, 32'h0);
    endtask

    task automatic t_keys();
        logic [31:0] v;
        lock();
        wr(A_CTRL, 32'h00);
        chk("R2 zero keys lock", {24'b0, ctrl_o}, 32'hFF);
        wr(A_KEY0, KEY0_VAL);
        wr(A_CTRL, 32'h00);
        chk("R1 one key not enough", {24'b0, ctrl_o}, 32'hFF);
        wr(A_KEY1, KEY1_VAL);
        wr(A_CTRL, 32'h01);
        chk("R1 both keys unlock", {24'b0, ctrl_o}, 32'h01);
        wr(A_KEY1, 32'h1234_5678);
        wr(A_CTRL, 32'h03);
        chk("R2 wrong key relocks", {24'b0, ctrl_o}, 32'h01);
        rd(A_CTRL, v); chk("R3 read while locked", v, 32'h01);
    endtask

    task automatic t_status();
        logic [31:0] v;
        unlock();
        @(negedge clk); alarm_hit = 1; @(negedge clk); alarm_hit = 0;
        rd(A_STAT, v); chk("R5 alarm set", v, 32'hC2);
        wr(A_STAT, 32'h40);
        rd(A_STAT, v); chk("R5 clear alarm only", v, 32'h82);
        wr(A_STAT, 32'h00);
        rd(A_STAT, v); chk("R5 write zero no effect", v, 32'h82);
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); chk("R5 clear power-up", v, 32'h02);
        @(negedge clk); alarm2_hit = 1; @(negedge clk); alarm2_hit = 0;
        rd(A_STAT, v); chk("R6 alarm2 sets bit7", v, 32'h82);
        // set and clear in the same cycle: set wins
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 32'hC0; alarm_hit = 1;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; alarm_hit = 0;
        rd(A_STAT, v); chk("R5 set wins over clear", v, 32'h42);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_IRQ, 32'hFFFF_FFFF);
        rd(A_IRQ, v); chk("R7 irq mask", v, 32'h11F);
        wr(A_IRQ, 32'h0, 1'b0);
        chk("R7 byte write keeps bit8", {23'b0, irq_en_o}, 32'h100);
        wr(A_IRQ, 32'h0);
        rd(A_IRQ, v); chk("R7 word zero clears all", v, 32'h0);
    endtask

    task automatic t_osc();
        logic [31:0] v;
        wr(A_OSC, 32'hFF);
        rd(A_OSC, v); chk("R8 osc implemented bits", v, 32'h58);
        chk("R8 osc_o", {24'b0, osc_o}, 32'h58);
    endtask

    task automatic t_scratch();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) wr(A_SCR0 + 8'(4 * i), 32'h1111_1111 * (i + 1));
        for (int i = 0; i < 3; i++) begin
            rd(A_SCR0 + 8'(4 * i), v);
            chk("R9 scratch readback", v, 32'h1111_1111 * (i + 1));
        end
        rd(A_SCR0 + 8'h4, v, 1'b0); chk("R10 byte read", v, 32'h22);
        wr(A_SCR0 + 8'h8, 32'hFFFF_FFA5, 1'b0);
        rd(A_SCR0 + 8'h8, v); chk("R10 byte write merge", v, 32'h3333_33A5);
        rd(8'h5C, v); chk("R11 unmapped reads 0", v, 32'h0);
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h5C, v); chk("R11 unmapped write dropped", v, 32'h0);
        rd(A_KEY0, v); chk("R9 0x6C not scratch", v, 32'h0);
        wr(A_KEY0, 32'hAAAA_AAAA);
        wr(A_SCR0, 32'h5);
        rd(A_SCR0, v); chk("R9 0x6C write relocks", v, 32'h1111_1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_locked();
        t_unlock_ctrl();
        t_keys();
        t_status();
        t_irq();
        t_osc();
        t_scratch();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule